// File: doc/BRIEF.md
# Coherency Connection Handshake Controller

This block sits on the interconnect side of one manager's coherency connect link. The manager raises a connect request to join the coherent domain and lowers it to leave. The controller answers with an acknowledge level that follows the request in a four-phase handshake. The acknowledge changes only once the transition has completed. While the manager is inside the domain, the controller lets the snoop arbiter issue snoops to it. It also keeps a count of the snoops issued but not yet answered.

Joining is immediate. Snoops are enabled as soon as the request is seen, and the acknowledge rises one cycle later. Leaving is a two-step drain. Snoop grant is withdrawn at once, and the acknowledge drops only after every outstanding snoop has been answered. A response that arrives with nothing outstanding sets a sticky error flag. The whole handshake is optional. With the enable parameter cleared, the acknowledge stays low and snoops are always allowed.

The snoop-issue path toward the arbiter is a valid/ready pair. The arbiter holds `snp_req_i` high while it wants to send a snoop. `snp_gnt_o` is its ready signal and depends combinationally on the request and the current enable. A snoop transfers on any cycle where both are high. Grant never stalls the count pulses, which are plain single-cycle strobes.

Top module: `coh_link_ctrl`

## Requirements
- R1: While and after reset, the acknowledge, snoop enable, grant, pending count and error flag are all 0.
- R2: The request passes through two synchronizer flops. Consider a rising request set up before clock edge E1. Snoop enable goes high after edge E3, and the acknowledge goes high after edge E4.
- R3: `snp_gnt_o` equals `snp_req_i AND snp_en_o` in the same cycle. No grant is given while snoops are disabled.
- R4: Consider a falling request set up before edge E1, with the link connected. Snoop enable drops after edge E3, while the acknowledge is still high.
- R5: After a disconnect begins, the acknowledge falls one edge after the pending count reaches 0. It never falls while the count is non-zero.
- R6: A request change that arrives while the acknowledge does not yet match the request is held off until the current phase ends. It is then acted on from the settled state.
- R7: The pending count increments on an issue pulse and decrements on a response pulse. It stays unchanged when both pulses occur together, and it saturates at `MAX_OUT`.
- R8: A response pulse with count 0 and no issue pulse in the same cycle sets `proto_err_o`. The flag stays high until reset.
- R9: With `COH_EN` = 0, the acknowledge stays 0 and snoop enable stays 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| conn_req_i | input | 1 | Connect request from the manager, may be asynchronous |
| conn_ack_o | output | 1 | Connect acknowledge to the manager |
| snp_req_i | input | 1 | Snoop issue valid from the arbiter |
| snp_gnt_o | output | 1 | Snoop issue ready to the arbiter |
| snp_en_o | output | 1 | Snoops currently allowed to this manager |
| snp_issue_i | input | 1 | One-cycle pulse, a snoop was sent |
| snp_resp_i | input | 1 | One-cycle pulse, a snoop response returned |
| snp_pending_o | output | CNT_W | Outstanding snoop count |
| proto_err_o | output | 1 | Sticky response-underflow error |

## Verification
Results arrive at different delays after a request edge. Snoop enable is due three edges later, because two synchronizer flops and the state register lie on that path. The acknowledge is due one edge after that, or one edge after the pending count reaches zero when disconnecting. Count and error updates land on the edge that samples the pulse, and grant follows its inputs in the same cycle. Every scenario task drives inputs 1 ns after a rising edge and checks outputs after counting edges one at a time. Each check therefore falls on the exact cycle computed above, with checks also made on the cycles just before the change.

// File: rtl/coh_link_pkg.sv
package coh_link_pkg;
  typedef enum logic [1:0] {
    LINK_DOWN    = 2'd0,
    LINK_JOINING = 2'd1,
    LINK_UP      = 2'd2,
    LINK_DRAIN   = 2'd3
  } link_state_e;
endpackage

// File: rtl/coh_req_sync.sv
module coh_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/coh_snoop_tracker.sv
module coh_snoop_tracker #(
  parameter int MAX_OUT = 15,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic             resp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, underflow;

  assign underflow = resp_i && !issue_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (issue_i && !resp_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (resp_i && !issue_i) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_q | underflow;
    end
  end

  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign err_o   = err_q;
endmodule

// File: rtl/coh_link_fsm.sv
module coh_link_fsm
  import coh_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        drained_i,
  output link_state_e state_o,
  output logic        ack_o,
  output logic        snp_en_o
);
  link_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LINK_DOWN:    if (req_i)     st_d = LINK_JOINING;
      LINK_JOINING:                st_d = LINK_UP;
      LINK_UP:      if (!req_i)    st_d = LINK_DRAIN;
      LINK_DRAIN:   if (drained_i) st_d = LINK_DOWN;
      default:                     st_d = LINK_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LINK_DOWN;
    else        st_q <= st_d;
  end

  assign state_o  = st_q;
  assign ack_o    = (st_q == LINK_UP) || (st_q == LINK_DRAIN);
  assign snp_en_o = (st_q == LINK_UP) || (st_q == LINK_JOINING);
endmodule

// File: rtl/coh_link_ctrl.sv
module coh_link_ctrl
  import coh_link_pkg::*;
#(
  parameter bit COH_EN  = 1'b1,
  parameter int MAX_OUT = 15,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conn_req_i,
  output logic             conn_ack_o,
  input  logic             snp_req_i,
  output logic             snp_gnt_o,
  output logic             snp_en_o,
  input  logic             snp_issue_i,
  input  logic             snp_resp_i,
  output logic [CNT_W-1:0] snp_pending_o,
  output logic             proto_err_o
);
  logic        req_sync;
  logic        drained;
  logic        fsm_ack, fsm_en;
  link_state_e fsm_state;

  coh_req_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(conn_req_i), .sync_o(req_sync)
  );

  coh_snoop_tracker #(.MAX_OUT(MAX_OUT)) u_track (
    .clk(clk), .rst_n(rst_n), .issue_i(snp_issue_i), .resp_i(snp_resp_i),
    .count_o(snp_pending_o), .empty_o(drained), .err_o(proto_err_o)
  );

  coh_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_sync), .drained_i(drained),
    .state_o(fsm_state), .ack_o(fsm_ack), .snp_en_o(fsm_en)
  );

  generate
    if (COH_EN) begin : g_hs
      assign conn_ack_o = fsm_ack;
      assign snp_en_o   = fsm_en;
    end else begin : g_nohs
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= 1'b1;
      end
      assign conn_ack_o = 1'b0;
      assign snp_en_o   = en_q;
    end
  endgenerate

  assign snp_gnt_o = snp_req_i && snp_en_o;
endmodule

// File: rtl/coh_link_ctrl_chk.sv
module coh_link_ctrl_chk #(
  parameter bit COH_EN  = 1'b1,
  parameter int MAX_OUT = 15,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_sync,
  input logic             conn_ack_o,
  input logic             snp_req_i,
  input logic             snp_gnt_o,
  input logic             snp_en_o,
  input logic [CNT_W-1:0] snp_pending_o,
  input logic             proto_err_o
);
  assert_gnt_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_gnt_o |-> (snp_en_o && snp_req_i));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(snp_pending_o) <= MAX_OUT);

  generate
    if (COH_EN) begin : g_hs_chk
      assert_ack_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_ack_o) |-> $past(snp_en_o));

      assert_join_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_en_o && !conn_ack_o) |=> conn_ack_o);

      assert_block_on_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_ack_o && !req_sync) |=> !snp_en_o);

      assert_ack_fall_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conn_ack_o) |-> ($past(snp_pending_o) == '0 && !$past(snp_en_o)));
    end else begin : g_off_chk
      assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (!conn_ack_o && snp_en_o));
    end
  endgenerate
endmodule

bind coh_link_ctrl coh_link_ctrl_chk #(.COH_EN(COH_EN), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .conn_ack_o(conn_ack_o),
  .snp_req_i(snp_req_i), .snp_gnt_o(snp_gnt_o), .snp_en_o(snp_en_o),
  .snp_pending_o(snp_pending_o), .proto_err_o(proto_err_o)
);

// File: tb/coh_link_ctrl_test.sv
module coh_link_ctrl_test;
  localparam int MAXO = 15;
  localparam int CW   = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, sreq = 1'b0, iss = 1'b0, rsp = 1'b0;
  logic ack, gnt, en, err;
  logic [CW-1:0] pend;
  logic ack_off, gnt_off, en_off, err_off;
  logic [CW-1:0] pend_off;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  coh_link_ctrl #(.COH_EN(1'b1), .MAX_OUT(MAXO)) uut (
    .clk(clk), .rst_n(rst_n), .conn_req_i(req), .conn_ack_o(ack),
    .snp_req_i(sreq), .snp_gnt_o(gnt), .snp_en_o(en),
    .snp_issue_i(iss), .snp_resp_i(rsp), .snp_pending_o(pend), .proto_err_o(err)
  );

  coh_link_ctrl #(.COH_EN(1'b0), .MAX_OUT(MAXO)) uut_off (
    .clk(clk), .rst_n(rst_n), .conn_req_i(req), .conn_ack_o(ack_off),
    .snp_req_i(sreq), .snp_gnt_o(gnt_off), .snp_en_o(en_off),
    .snp_issue_i(1'b0), .snp_resp_i(1'b0), .snp_pending_o(pend_off), .proto_err_o(err_off)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic t_reset();
    chk("R1 ack", ack, 0);
    chk("R1 en", en, 0);
    sreq = 1'b1; #0.5;
    chk("R1 gnt", gnt, 0);
    sreq = 1'b0;
    chk("R1 pending", pend, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    step();
    chk("R9 off ack", ack_off, 0);
    chk("R9 off en", en_off, 1);
  endtask

  task automatic t_connect();
    req = 1'b1;
    step(); chk("R2 en E1", en, 0);
    step(); chk("R2 en E2", en, 0);
    step(); chk("R2 en E3", en, 1); chk("R2 ack E3", ack, 0);
    step(); chk("R2 ack E4", ack, 1);
  endtask

  task automatic t_grant();
    sreq = 1'b1; #0.5;
    chk("R3 gnt on", gnt, 1);
    sreq = 1'b0; #0.5;
    chk("R3 gnt idle", gnt, 0);
  endtask

  task automatic t_count();
    iss = 1'b1; step(); chk("R7 inc1", pend, 1);
    step(); chk("R7 inc2", pend, 2);
    rsp = 1'b1; step(); chk("R7 both", pend, 2);
    iss = 1'b0; step(); chk("R7 dec", pend, 1);
    rsp = 1'b0;
    iss = 1'b1; step(); iss = 1'b0;
    chk("R7 pending2", pend, 2);
  endtask

  task automatic t_drain_with_reentry();
    req = 1'b0;
    step(); chk("R4 en E1", en, 1);
    step(); chk("R4 en E2", en, 1);
    step(); chk("R4 en E3", en, 0); chk("R4 ack held", ack, 1);
    sreq = 1'b1; #0.5; chk("R3 gnt blocked", gnt, 0); sreq = 1'b0;
    req = 1'b1;
    step(); step(); step();
    chk("R6 ack held during drain", ack, 1);
    chk("R6 en held low", en, 0);
    rsp = 1'b1; step(); chk("R5 pending1", pend, 1); chk("R5 ack while pending", ack, 1);
    step(); rsp = 1'b0; chk("R5 pending0", pend, 0); chk("R5 ack before edge", ack, 1);
    step(); chk("R5 ack fell", ack, 0); chk("R5 en off", en, 0);
    step(); chk("R6 rejoin en", en, 1); chk("R6 rejoin ack", ack, 0);
    step(); chk("R6 rejoin ack up", ack, 1);
    chk("R8 no err", err, 0);
  endtask

  task automatic t_quick_leave();
    req = 1'b0;
    step(); step(); step();
    chk("R4 en quick", en, 0);
    step(); chk("R5 ack quick fall", ack, 0);
    step(); chk("R1 stays down", ack, 0);
  endtask

  task automatic t_saturate_and_err();
    iss = 1'b1;
    for (int i = 0; i < MAXO + 2; i++) step();
    iss = 1'b0;
    chk("R7 saturate", pend, MAXO);
    rsp = 1'b1;
    for (int i = 0; i < MAXO; i++) step();
    chk("R7 back to zero", pend, 0);
    chk("R8 no err yet", err, 0);
    step(); rsp = 1'b0;
    chk("R8 underflow err", err, 1);
    chk("R8 pending stays 0", pend, 0);
    iss = 1'b1; step(); iss = 1'b0;
    step();
    chk("R8 err sticky", err, 1);
    chk("R9 off ack late", ack_off, 0);
    chk("R9 off en late", en_off, 1);
  endtask

  initial begin
    step();
    t_reset();
    t_connect();
    t_grant();
    t_count();
    t_drain_with_reentry();
    t_quick_leave();
    t_saturate_and_err();
    done = 1'b1;
    finish_run();
  end
endmodule